// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Stored-Program Processor

This block is a small processor whose instructions and data live together in one 256-byte internal memory. It owns sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. Every instruction is two bytes long and runs through a fixed walk of states: read the high byte, read the low byte, decode (which also advances the program counter), execute, and for loads a final memory-access state that writes the fetched byte into a register.

A 16-bit instruction holds a 4-bit op-code in bits 15:12 and a 12-bit operand. Register fields are named here as A = bits 11:8, B = bits 7:4, C = bits 3:0 and K = bits 7:0. The op-codes are: 1 RA <= mem[K]; 2 RA <= K; 3 mem[K] <= RA; 4 RB <= RC; 5 RA <= RB + RC; 7 RA <= RB | RC; 8 RA <= RB & RC; 9 RA <= RB ^ RC; A RA <= RA rotated right by C; B jump to K if RA == R0; C halt; D RB <= mem[RC]; E mem[RC] <= RB; F jump to K if RA <= R0 as signed numbers. Op-codes 0 and 6 do nothing.

The memory is loaded through a write port that the surroundings drive while the processor sits in reset. A combinational peek port reads any cell. The start address comes from an input that the program counter takes during reset.

Top module: `cpu8`

## Requirements
- R1: While rst_n is low, pc_o equals start_pc, halted is 0 and all sixteen registers read as zero once the processor runs.
- R2: An instruction is read with its high byte from the cell at the program counter and its low byte from the next cell. The program counter then grows by 2. A non-load instruction takes 4 clock cycles and a load (op 1 or D) takes 5.
- R3: Op 2 writes K into RA. Op 1 writes mem[K] into RA.
- R4: Op 3 writes RA into memory cell K.
- R5: Op D writes mem[RC] into RB. Op E writes RB into memory cell RC.
- R6: Op 4 copies RC into RB.
- R7: Op 5 writes (RB + RC) mod 256 into RA.
- R8: Ops 7, 8 and 9 write the bitwise OR, AND and XOR of RB and RC into RA.
- R9: Op A rotates RA right by (C mod 8) bit places, with the bits that fall off the low end coming back in at the top.
- R10: Op B loads K into the program counter when RA equals R0. Otherwise it falls through to the next instruction.
- R11: Op F loads K into the program counter when RA, read as a signed byte, is less than or equal to R0, also read as signed. Otherwise it falls through.
- R12: Op C raises halted, which stays high until reset. While halted is high, mem_rd and mem_wr stay low.
- R13: Ops 0 and 6 change no register and no memory cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pc | input | 8 | Program counter value taken during reset |
| ld_we | input | 1 | Write strobe of the memory preload port |
| ld_addr | input | 8 | Preload address |
| ld_data | input | 8 | Preload byte |
| pk_addr | input | 8 | Peek address |
| pk_data | output | 8 | Memory byte at pk_addr, combinational |
| mem_rd | output | 1 | Processor reads memory this cycle |
| mem_wr | output | 1 | Processor writes memory this cycle |
| pc_o | output | 8 | Current program counter |
| halted | output | 1 | Processor has executed halt |

## Verification
The assertions assume that the preload port is used only while rst_n is low. This matters because a preload write wins over a processor store to the same cycle, and a store that loses would break the link the checks draw between mem_wr and the store op-codes. They also assume that rst_n is held across at least one clock edge, so that every history they look at begins in the fetch-high state. The bench writes the program and data bytes only inside a reset window and drops reset only after the last byte is in place. The program is built so that every branch target is an even address inside the program area, so the fetch order is never broken by a misaligned jump.

// File: rtl/cpu8.sv
module cpu8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] start_pc,
  input  logic       ld_we,
  input  logic [7:0] ld_addr,
  input  logic [7:0] ld_data,
  input  logic [7:0] pk_addr,
  output logic [7:0] pk_data,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [7:0] pc_o,
  output logic       halted
);
  typedef enum logic [2:0] {S_FH, S_FL, S_DC, S_EX, S_MA, S_HLT} st_t;

  st_t         st;
  logic [7:0]  mem [256];
  logic [7:0]  rf  [16];
  logic [7:0]  pc, rdata;
  logic [15:0] ir;

  wire [3:0] op = ir[15:12];
  wire [3:0] fa = ir[11:8];
  wire [3:0] fb = ir[7:4];
  wire [3:0] fc = ir[3:0];
  wire [7:0] k  = ir[7:0];
  wire [7:0] va = rf[fa];
  wire [7:0] vb = rf[fb];
  wire [7:0] vc = rf[fc];

  wire is_load  = (op == 4'h1) || (op == 4'hD);
  wire is_store = (op == 4'h3) || (op == 4'hE);

  logic [7:0]  maddr, wdata, alu;
  logic [15:0] rot2;
  logic        wr_en, take;
  logic [3:0]  wsel;

  assign rot2 = {va, va} >> fc[2:0];

  always_comb begin
    maddr = pc;
    if (st == S_FL) maddr = pc + 8'd1;
    else if (st == S_EX) maddr = (op == 4'h1 || op == 4'h3) ? k : vc;
  end

  assign mem_rd  = (st == S_FH) || (st == S_FL) || (st == S_EX && is_load);
  assign mem_wr  = (st == S_EX) && is_store;
  assign wdata   = (op == 4'h3) ? va : vb;
  assign pk_data = mem[pk_addr];
  assign pc_o    = pc;
  assign halted  = (st == S_HLT);

  always_comb begin
    alu   = 8'h00;
    wr_en = 1'b0;
    wsel  = fa;
    case (op)
      4'h2: begin alu = k;         wr_en = 1'b1; end
      4'h4: begin alu = vc;        wr_en = 1'b1; wsel = fb; end
      4'h5: begin alu = vb + vc;   wr_en = 1'b1; end
      4'h7: begin alu = vb | vc;   wr_en = 1'b1; end
      4'h8: begin alu = vb & vc;   wr_en = 1'b1; end
      4'h9: begin alu = vb ^ vc;   wr_en = 1'b1; end
      4'hA: begin alu = rot2[7:0]; wr_en = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    take = 1'b0;
    if (op == 4'hB) take = (va == rf[0]);
    else if (op == 4'hF) take = ($signed(va) <= $signed(rf[0]));
  end

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[maddr] <= wdata;
    if (mem_rd) rdata <= mem[maddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FH;
      pc <= start_pc;
      ir <= 16'h0000;
      for (int i = 0; i < 16; i++) rf[i] <= 8'h00;
    end else begin
      case (st)
        S_FH: st <= S_FL;
        S_FL: begin ir[15:8] <= rdata; st <= S_DC; end
        S_DC: begin ir[7:0] <= rdata; pc <= pc + 8'd2; st <= S_EX; end
        S_EX: begin
          if (wr_en) rf[wsel] <= alu;
          if (take) pc <= k;
          if (op == 4'hC) st <= S_HLT;
          else if (is_load) st <= S_MA;
          else st <= S_FH;
        end
        S_MA: begin
          rf[(op == 4'h1) ? fa : fb] <= rdata;
          st <= S_FH;
        end
        default: st <= S_HLT;
      endcase
    end
  end

  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DC) |=> (pc_o == $past(pc_o) + 8'd2));
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FH) |=> (st == S_FL && mem_rd));
  // R4
  wr_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (st == S_EX && (ir[15:12] == 4'h3 || ir[15:12] == 4'hE)));
  // R3
  load_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MA) |-> ($past(st) == S_EX && $past(mem_rd)));
endmodule

// File: tb/sim_cpu8.sv
`timescale 1ns/1ps
module sim_cpu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] start_pc = 8'h00;
  logic       ld_we = 1'b0;
  logic [7:0] ld_addr = 8'h00, ld_data = 8'h00, pk_addr = 8'h00;
  logic [7:0] pk_data, pc_o;
  logic       mem_rd, mem_wr, halted;

  cpu8 u0 (.clk(clk), .rst_n(rst_n), .start_pc(start_pc), .ld_we(ld_we),
           .ld_addr(ld_addr), .ld_data(ld_data), .pk_addr(pk_addr),
           .pk_data(pk_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
           .pc_o(pc_o), .halted(halted));

  always #4 clk = ~clk;

  typedef struct { logic [7:0] a; logic [7:0] v; string tag; } exp_t;
  exp_t q[$];
  int errs = 0, checks = 0, quiet_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_mem(logic [7:0] a, logic [7:0] v, string tag);
    exp_t e;
    e.a = a; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic poke(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic pw(logic [7:0] a, logic [15:0] w);
    poke(a, w[15:8]);
    poke(a + 8'd1, w[7:0]);
  endtask

  // scoreboard monitor: compares memory cells once the program halts
  always begin
    @(negedge clk);
    if (rst_n && halted && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      pk_addr = e.a;
      #1;
      check(e.tag, pk_data, e.v);
    end
  end

  always @(negedge clk)
    if (rst_n && halted && (mem_rd || mem_wr)) quiet_bad++;

  task automatic run(logic [7:0] sp, int exp_cyc, logic [7:0] exp_pc);
    int n;
    start_pc = sp;
    @(negedge clk);
    @(negedge clk);
    check("R1 pc during reset", pc_o, sp);
    check("R1 halted during reset", halted, 0);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 2000) begin
      @(posedge clk);
      n++;
      #1;
    end
    check("R2 cycles to halt", n, exp_cyc);
    check("R2 pc after halt", pc_o, exp_pc);
    while (q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R12 halted held", halted, 1);
    check("R12 no access after halt", quiet_bad, 0);
    rst_n = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    poke(8'h40, 8'h5C); poke(8'h41, 8'h77);
    poke(8'h5B, 8'h11); poke(8'h5C, 8'h11);
    poke(8'h5D, 8'h11); poke(8'h5E, 8'h11);
    pw(8'hA0, 16'h2126); pw(8'hA2, 16'h22FF); pw(8'hA4, 16'h8312);
    pw(8'hA6, 16'h8410); pw(8'hA8, 16'h7512); pw(8'hAA, 16'h7610);
    pw(8'hAC, 16'h9712); pw(8'hAE, 16'h5812); pw(8'hB0, 16'h4091);
    pw(8'hB2, 16'hA903); pw(8'hB4, 16'h3350); pw(8'hB6, 16'h3451);
    pw(8'hB8, 16'h3552); pw(8'hBA, 16'h3653); pw(8'hBC, 16'h3754);
    pw(8'hBE, 16'h3855); pw(8'hC0, 16'h3956); pw(8'hC2, 16'h2A57);
    pw(8'hC4, 16'hE01A); pw(8'hC6, 16'h2C40); pw(8'hC8, 16'hD0DC);
    pw(8'hCA, 16'h3D58); pw(8'hCC, 16'h1E41); pw(8'hCE, 16'h3E59);
    pw(8'hD0, 16'h0123); pw(8'hD2, 16'h6123); pw(8'hD4, 16'h315A);
    pw(8'hD6, 16'h2F00); pw(8'hD8, 16'hBFDC); pw(8'hDA, 16'h3F5B);
    pw(8'hDC, 16'h2F05); pw(8'hDE, 16'hBFE2); pw(8'hE0, 16'h3F5C);
    pw(8'hE2, 16'h2F80); pw(8'hE4, 16'hFFE8); pw(8'hE6, 16'h3F5D);
    pw(8'hE8, 16'h2F05); pw(8'hEA, 16'hFFEE); pw(8'hEC, 16'h3F5E);
    pw(8'hEE, 16'hC000);
    expect_mem(8'h50, 8'h26, "R8 and all-ones");
    expect_mem(8'h51, 8'h00, "R8 and zero");
    expect_mem(8'h52, 8'hFF, "R8 or");
    expect_mem(8'h53, 8'h26, "R8 or zero");
    expect_mem(8'h54, 8'hD9, "R8 xor");
    expect_mem(8'h55, 8'h25, "R7 add wrap");
    expect_mem(8'h56, 8'hC4, "R9 rotate after R6 move");
    expect_mem(8'h57, 8'h26, "R5 indirect store");
    expect_mem(8'h58, 8'h5C, "R5 indirect load");
    expect_mem(8'h59, 8'h77, "R3 direct load");
    expect_mem(8'h5A, 8'h26, "R13 nop ops keep R1");
    expect_mem(8'h5B, 8'h11, "R10 taken skips store");
    expect_mem(8'h5C, 8'h05, "R10 not taken falls through");
    expect_mem(8'h5D, 8'h11, "R11 signed negative taken");
    expect_mem(8'h5E, 8'h05, "R11 positive not taken");
    expect_mem(8'h40, 8'h5C, "R4 data cell untouched");
    // 38 instructions executed, two of them loads
    run(8'hA0, 38 * 4 + 2, 8'hF0);

    poke(8'h60, 8'hAB); poke(8'h61, 8'hAB);
    pw(8'h00, 16'h3F60); pw(8'h02, 16'h3161); pw(8'h04, 16'hC000);
    expect_mem(8'h60, 8'h00, "R1 RF cleared by reset");
    expect_mem(8'h61, 8'h00, "R1 R1 cleared by reset");
    run(8'h00, 12, 8'h06);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule